// File: doc/BRIEF.md
# Handshaked Byte Output Port Pair

This block holds two byte-wide output channels, A and B. Each channel has a strobed handshake toward a peripheral. The processor side writes a byte by putting it on a shared data bus, asserting one channel select and pulsing an active-low write strobe. The chosen channel latches the byte and drives it on its output pins. When the strobe is released, the channel pulls its active-low "buffer full" flag low to tell the peripheral that an unconsumed byte is waiting.

The peripheral takes the byte and answers with an active-low acknowledge pulse. On the falling edge of that pulse the channel returns its buffer-full flag high. If the channel's interrupt enable is set, it also raises an interrupt request meaning "ready for the next byte". That request stays up until the processor starts its next write to the same channel.

The write strobe, the selects, the data and both acknowledges are asynchronous to the system clock. They pass through two-flop synchronisers, and all edges are detected in the system clock domain. The flags of both channels are gathered onto one 8-bit control lane at fixed bit positions. The rest of a wider port decodes these positions.

Top module: `hs_out_ports`

## Requirements
- R1: After reset both data outputs are 0, both buffer-full flags are 1 (empty), both interrupt requests are 0, and `ctl_lane` reads 8'h82.
- R2: While `wr_n` is low with `sel_a` (or `sel_b`) high, the byte on `cpu_data` is latched into channel A (or B) and appears on `out_a` (or `out_b`). The other channel's output does not change.
- R3: A channel's buffer-full flag stays as it was while the strobe is low. It goes low (0) only after `wr_n` returns high, and this happens even if a byte is already pending.
- R4: A buffer-full flag that is low stays low until the falling edge of that channel's acknowledge input. After that edge it returns to 1.
- R5: The acknowledge that returns the flag to 1 sets the interrupt request to the value of that channel's enable input (`ien_a` / `ien_b`). With the enable at 0, no request is raised.
- R6: A channel's interrupt request is cleared by the falling edge of the write strobe while that channel is selected. A write to the other channel leaves it untouched.
- R7: An acknowledge falling edge while the channel's buffer-full flag is already 1 changes nothing and raises no interrupt request.
- R8: `ctl_lane` layout: bit 7 = channel A buffer-full (active low), bit 3 = channel A interrupt, bit 1 = channel B buffer-full (active low), bit 0 = channel B interrupt. All other bits read 0.
- R9: A write strobe pulse with neither select high changes no output, flag or request.
- R10: Every input takes effect at the third rising clock edge after it changes, because of the two synchroniser stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_data | input | DW | Byte written by the processor |
| wr_n | input | 1 | Active-low write strobe, shared by both channels |
| sel_a | input | 1 | Selects channel A for the write |
| sel_b | input | 1 | Selects channel B for the write |
| ack_a_n | input | 1 | Active-low acknowledge from the channel A peripheral |
| ack_b_n | input | 1 | Active-low acknowledge from the channel B peripheral |
| ien_a | input | 1 | Interrupt enable for channel A |
| ien_b | input | 1 | Interrupt enable for channel B |
| out_a | output | DW | Channel A output byte |
| out_b | output | DW | Channel B output byte |
| ctl_lane | output | 8 | Buffer-full and interrupt flags of both channels (R8 layout) |

## Verification
A table of writes drives the handshake with bytes of all-zero, all-one and mixed bit patterns. Writes alternate between the channels, so a byte or flag that leaks into the wrong channel shows up. Each entry sets the interrupt enable on or off and either acknowledges the byte or leaves it pending. This separates a request that follows the enable from one that is stuck, and a buffer-full flag cleared by the acknowledge from one cleared by time. One entry writes over a byte that is still pending, and during every strobe the flags are sampled before release, to check that buffer-full waits for the strobe's end and that the request is cleared by its start. Directed cases then try an acknowledge on an empty channel and a strobe with no select.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int CTL_W      = 8;
    localparam int POS_FULL_A = 7;
    localparam int POS_IRQ_A  = 3;
    localparam int POS_FULL_B = 1;
    localparam int POS_IRQ_B  = 0;
    localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hs_edge.sv
module hs_edge
    import hs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          sel,
    input  logic [DW-1:0] data,
    input  logic          ack_n,
    output logic          wr_lo,
    output logic          wr_rise,
    output logic          wr_fall,
    output logic          ack_fall,
    output logic [DW-1:0] data_s
);
    localparam int BW = DW + 2;
    localparam logic [BW-1:0] BUNDLE_RST = {1'b1, 1'b0, {DW{1'b0}}};

    typedef struct packed {
        logic wr_p;
        logic sel_p;
        logic ack_p;
    } prev_t;

    logic [BW-1:0] bundle_s;
    logic          ack_s;
    logic          wr_s, sel_s;
    prev_t         prev_d, prev_q;

    hs_sync2 #(.W(BW), .STAGES(SYNC_DEPTH), .RST_VAL(BUNDLE_RST)) u_wr_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din ({wr_n, sel, data}),
        .dout (bundle_s)
    );

    hs_sync2 #(.W(1), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_ack_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (ack_n),
        .dout (ack_s)
    );

    assign wr_s   = bundle_s[BW-1];
    assign sel_s  = bundle_s[BW-2];
    assign data_s = bundle_s[DW-1:0];

    always_comb begin
        prev_d.wr_p  = wr_s;
        prev_d.sel_p = sel_s;
        prev_d.ack_p = ack_s;
        wr_lo    = !wr_s && sel_s;
        wr_fall  = prev_q.wr_p && !wr_s && sel_s;
        wr_rise  = !prev_q.wr_p && wr_s && prev_q.sel_p;
        ack_fall = prev_q.ack_p && !ack_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{wr_p: 1'b1, sel_p: 1'b0, ack_p: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_rise,
    input  logic          wr_fall,
    input  logic          ack_fall,
    input  logic          ien,
    input  logic [DW-1:0] data_s,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] dout;
        logic          full_n;
        logic          irq;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_fall) begin
            st_d.irq = 1'b0;
        end
        if (wr_lo) begin
            st_d.dout = data_s;
        end
        if (wr_rise) begin
            st_d.full_n = 1'b0;
        end else if (ack_fall && !st_q.full_n) begin
            st_d.full_n = 1'b1;
            st_d.irq    = ien;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{dout: '0, full_n: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout   = st_q.dout;
    assign full_n = st_q.full_n;
    assign irq    = st_q.irq;
endmodule

// File: rtl/hs_out_ports.sv
module hs_out_ports
    import hs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    cpu_data,
    input  logic             wr_n,
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic             ack_a_n,
    input  logic             ack_b_n,
    input  logic             ien_a,
    input  logic             ien_b,
    output logic [DW-1:0]    out_a,
    output logic [DW-1:0]    out_b,
    output logic [CTL_W-1:0] ctl_lane
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]         sel_v, ack_v, ien_v;
    logic [NPORT-1:0]         wr_lo, wr_rise, wr_fall, ack_fall;
    logic [NPORT-1:0]         full_n, irq;
    logic [NPORT-1:0][DW-1:0] data_s, dout_v;

    assign sel_v = {sel_b, sel_a};
    assign ack_v = {ack_b_n, ack_a_n};
    assign ien_v = {ien_b, ien_a};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        hs_edge #(.DW(DW)) u_edge (
            .clk (clk),
            .rst_n (rst_n),
            .wr_n (wr_n),
            .sel (sel_v[p]),
            .data (cpu_data),
            .ack_n (ack_v[p]),
            .wr_lo (wr_lo[p]),
            .wr_rise (wr_rise[p]),
            .wr_fall (wr_fall[p]),
            .ack_fall (ack_fall[p]),
            .data_s (data_s[p])
        );

        hs_out_chan #(.DW(DW)) u_chan (
            .clk (clk),
            .rst_n (rst_n),
            .wr_lo (wr_lo[p]),
            .wr_rise (wr_rise[p]),
            .wr_fall (wr_fall[p]),
            .ack_fall (ack_fall[p]),
            .ien (ien_v[p]),
            .data_s (data_s[p]),
            .dout (dout_v[p]),
            .full_n (full_n[p]),
            .irq (irq[p])
        );
    end

    assign out_a = dout_v[0];
    assign out_b = dout_v[1];

    always_comb begin
        ctl_lane             = '0;
        ctl_lane[POS_FULL_A] = full_n[0];
        ctl_lane[POS_IRQ_A]  = irq[0];
        ctl_lane[POS_FULL_B] = full_n[1];
        ctl_lane[POS_IRQ_B]  = irq[1];
    end
endmodule

// File: rtl/hs_out_ports_chk.sv
module hs_out_ports_chk #(
    parameter int NPORT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] wr_rise,
    input logic [NPORT-1:0] wr_fall,
    input logic [NPORT-1:0] ack_fall,
    input logic [NPORT-1:0] full_n,
    input logic [NPORT-1:0] irq,
    input logic [NPORT-1:0] ien_v
);
    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R3
        full_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(full_n[p]) |-> $past(wr_rise[p]));
        // R4
        full_cleared_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(full_n[p]) |-> $past(ack_fall[p]));
        // R5
        irq_follows_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_fall[p] && !full_n[p] && !wr_rise[p]) |=> (irq[p] == $past(ien_v[p])));
        // R6
        irq_cleared_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_fall[p] && !ack_fall[p]) |=> !irq[p]);
        // R7
        irq_needs_pending_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[p]) |-> $past(ack_fall[p] && !full_n[p]));
    end
endmodule

bind hs_out_ports hs_out_ports_chk #(.NPORT(2)) u_hs_chk (
    .clk (clk),
    .rst_n (rst_n),
    .wr_rise (wr_rise),
    .wr_fall (wr_fall),
    .ack_fall (ack_fall),
    .full_n (full_n),
    .irq (irq),
    .ien_v (ien_v)
);

// File: tb/test_hs_out_ports.sv
module test_hs_out_ports;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_data = '0;
    logic       wr_n = 1'b1, sel_a = 1'b0, sel_b = 1'b0;
    logic       ack_a_n = 1'b1, ack_b_n = 1'b1;
    logic       ien_a = 1'b0, ien_b = 1'b0;
    logic [7:0] out_a, out_b, ctl_lane;

    int nvec = 0;
    int nbad = 0;

    logic [7:0] e_out [2];
    logic       e_full_n [2];
    logic       e_irq [2];

    always #5 clk = ~clk;

    hs_out_ports #(.DW(8)) i_hs_out_ports (
        .clk (clk), .rst_n (rst_n), .cpu_data (cpu_data), .wr_n (wr_n),
        .sel_a (sel_a), .sel_b (sel_b), .ack_a_n (ack_a_n), .ack_b_n (ack_b_n),
        .ien_a (ien_a), .ien_b (ien_b), .out_a (out_a), .out_b (out_b),
        .ctl_lane (ctl_lane)
    );

    // {port(1), data(8), ien(1), ack(1)}
    localparam int NV = 8;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 8'h5A, 1'b1, 1'b1},
        {1'b1, 8'hC3, 1'b1, 1'b1},
        {1'b0, 8'h00, 1'b0, 1'b1},
        {1'b1, 8'hFF, 1'b0, 1'b0},
        {1'b1, 8'h81, 1'b1, 1'b1},
        {1'b0, 8'hA5, 1'b1, 1'b0},
        {1'b0, 8'h3C, 1'b0, 1'b1},
        {1'b1, 8'h7E, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ctl();
        logic [7:0] c = '0;
        c[7] = e_full_n[0];
        c[3] = e_irq[0];
        c[1] = e_full_n[1];
        c[0] = e_irq[1];
        return c;
    endfunction

    task automatic check_all(input string req);
        chk({req, " out_a"}, out_a, e_out[0]);
        chk({req, " out_b"}, out_b, e_out[1]);
        chk({req, " ctl_lane (R8)"}, ctl_lane, exp_ctl());
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input bit port, input logic [7:0] d);
        cpu_data = d;
        sel_a = (port == 1'b0);
        sel_b = (port == 1'b1);
        wr_n = 1'b0;
        cyc(3);
        // R2 data latched while low; R3 flag unchanged; R6 request cleared
        e_out[port] = d;
        e_irq[port] = 1'b0;
        check_all("R2/R3/R6 strobe low");
        wr_n = 1'b1;
        cyc(1);
        sel_a = 1'b0;
        sel_b = 1'b0;
        cyc(4);
        e_full_n[port] = 1'b0;
        check_all("R3 after strobe release");
    endtask

    task automatic ack_pulse(input bit port);
        if (port) ack_b_n = 1'b0; else ack_a_n = 1'b0;
        cyc(3);
        ack_a_n = 1'b1;
        ack_b_n = 1'b1;
        cyc(4);
        if (!e_full_n[port]) begin
            e_full_n[port] = 1'b1;
            e_irq[port] = port ? ien_b : ien_a;
        end
    endtask

    initial begin
        #2ms;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            e_out[p] = '0; e_full_n[p] = 1'b1; e_irq[p] = 1'b0;
        end
        cyc(3);
        // R1 reset state
        check_all("R1 reset");
        chk("R1 ctl_lane value", ctl_lane, 8'h82);
        rst_n = 1'b1;
        cyc(2);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][10]) ien_b = VEC[v][1]; else ien_a = VEC[v][1];
            write_byte(VEC[v][10], VEC[v][9:2]);
            if (VEC[v][0]) begin
                ack_pulse(VEC[v][10]);
                // R4 flag back high, R5 request follows enable
                check_all("R4/R5 after ack");
            end
        end

        // R7 ack while empty: channel A is empty, enable on
        ien_a = 1'b1;
        ack_pulse(1'b0);
        check_all("R7 ack on empty A");

        // R9 strobe without select
        cpu_data = 8'h99;
        wr_n = 1'b0;
        cyc(3);
        wr_n = 1'b1;
        cyc(5);
        check_all("R9 unselected strobe");

        // R6 other-channel write keeps request; R10 latency
        write_byte(1'b0, 8'h11);
        ack_pulse(1'b0);
        check_all("R5 irq A set");
        write_byte(1'b1, 8'h22);
        check_all("R6 B write leaves A irq");

        // R10: ack takes effect at the third edge, not the second
        ack_b_n = 1'b0;
        cyc(2);
        check_all("R10 before third edge");
        cyc(1);
        e_full_n[1] = 1'b1;
        e_irq[1] = ien_b;
        check_all("R10 at third edge");
        ack_b_n = 1'b1;
        cyc(4);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule